// File: doc/BRIEF.md
# Receive Buffer Ring Writer

This block sits between a receive byte stream and system memory. It places incoming bytes into a ring of memory buffers. Each buffer is described by an eight-byte descriptor in a table. The block starts at a programmed table base and reads each descriptor in turn. While a buffer is open, it keeps a next-byte address and a down-counter of the room left. A buffer closes in one of three ways: it fills, the stream marks end of frame, or the stream flags an error. On close, the block writes a status-and-length word back into the descriptor and moves on to the next descriptor.

Descriptor layout, little-endian, byte address `d`:
- Word 0 at `d`:
  - bit 31: empty. Set by software to hand the buffer over.
  - bit 30: wrap.
  - bit 29: last-in-frame.
  - bit 28: error.
  - bits 15:0: byte count.
- Word 1 at `d+4`: the buffer byte address, in bits `AW-1:0`.

Software sets up the block through four registers, selected by `reg_sel`:
- 0: table base.
- 1: maximum buffer length.
- 2: control. Bit 0 enables the block; bit 1 selects narrow (8-bit) FIFO mode.
- 3: current-descriptor pointer.

Top module: `rx_bd_walker`

## Requirements
- R1: When a buffer opens, its down-counter is loaded with the maximum length. The buffer receives at most that many bytes. When the count reaches zero, the buffer closes with last=0 and error=0, and the following bytes go to the next descriptor.
- R2: A byte flagged end-of-frame is stored and closes the buffer early. The write-back has last=1 and the count of bytes stored, including when that byte also fills the buffer.
- R3: A beat flagged error stores no byte and closes the buffer. The write-back has error=1, last=0 and the count already stored, which may be zero.
- R4: Bytes are written one per beat, starting at the buffer address taken from descriptor word 1. The address steps by one per stored byte.
- R5: On close, word 0 is written back with empty=0, the wrap bit as read, last in bit 29, error in bit 28 and the count in bits 15:0. The current-descriptor pointer then steps by 8.
- R6: Reset clears the current-descriptor pointer to 0, the base's reset value. Closing a descriptor whose wrap bit is set reloads the pointer from the table base.
- R7: A write to the maximum length does not change the buffer in progress. The new value applies from the next buffer opened.
- R8: A maximum-length write is ignored if the value is 0. It is also ignored if its two low bits are nonzero while control bit 1 (narrow) is 0. With narrow set, any nonzero value is taken.
- R9: A write to the current-descriptor pointer takes effect only while the block is idle (disabled) or stalled on a non-empty descriptor. While a buffer is open, the write is ignored.
- R10: If the next descriptor's empty bit is clear, `busy` is raised and `in_ready` is held low. Nothing is written until software sets the empty bit.
- R11: During reset, `in_ready`, `busy` and `mem_we` are low and `cur_bd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Receive beat present |
| in_data | input | 8 | Receive byte |
| in_eof | input | 1 | Beat ends the frame |
| in_err | input | 1 | Beat signals a receive error (byte dropped) |
| in_ready | output | 1 | Beat accepted this cycle |
| bd_raddr | output | AW | Descriptor read address |
| bd_rdata | input | 32 | Descriptor read data, same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wbyte | output | 1 | 1: byte write, 0: 32-bit descriptor write |
| mem_addr | output | AW | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| busy | output | 1 | Stalled on a descriptor not marked empty |
| cur_bd | output | AW | Current-descriptor pointer |

## Verification
The hardest case to reach is a length change landing while a buffer is half full. It has to be followed by a fill that crosses into the next buffer. The bench sends two bytes, rewrites the maximum length between beats, and then finishes the frame. The expected buffer sizes then come from two different capacities.

The stall is reached in a similar way. The bench clears the empty bit of the descriptor after the open one before a frame longer than one buffer. It then holds the ring there for a while before releasing it.

// File: rtl/rx_bd_walker.sv
module rx_bd_walker #(
  parameter int AW = 8,
  parameter logic [15:0] MAXLEN_RST = 16'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eof,
  input  logic          in_err,
  output logic          in_ready,
  output logic [AW-1:0] bd_raddr,
  input  logic [31:0]   bd_rdata,
  output logic          mem_we,
  output logic          mem_wbyte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          busy,
  output logic [AW-1:0] cur_bd
);
  localparam logic [AW-1:0] BD_STEP  = AW'(8);
  localparam logic [AW-1:0] ADDR_OFS = AW'(4);

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_ADDR, S_OPEN, S_CLOSE} st_t;
  st_t st;

  logic [AW-1:0] base, bdp, buf_ptr;
  logic [15:0]   maxlen, cnt, olen;
  logic          en, narrow, wrap_l, last_l, err_l;
  logic          buf_open, bd_empty, take, ml_ok, ptr_ok, closing;
  logic          unused_bits;

  assign buf_open  = st == S_OPEN;
  assign closing   = st == S_CLOSE;
  assign bd_empty  = bd_rdata[31];
  assign busy      = st == S_HEAD && en && !bd_empty;
  assign in_ready  = buf_open;
  assign take      = buf_open && in_valid;
  assign ml_ok     = reg_wdata != 16'd0 && (narrow || reg_wdata[1:0] == 2'b00);
  assign ptr_ok    = st == S_IDLE || busy;
  assign cur_bd    = bdp;
  assign bd_raddr  = (st == S_ADDR) ? bdp + ADDR_OFS : bdp;
  assign mem_we    = (take && !in_err) || closing;
  assign mem_wbyte = !closing;
  assign mem_addr  = closing ? bdp : buf_ptr;
  assign mem_wdata = closing ? {1'b0, wrap_l, last_l, err_l, 12'd0, olen - cnt}
                             : {24'd0, in_data};
  assign unused_bits = ^bd_rdata[29:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base    <= '0;
      bdp     <= '0;
      buf_ptr <= '0;
      maxlen  <= MAXLEN_RST;
      cnt     <= '0;
      olen    <= '0;
      en      <= 1'b0;
      narrow  <= 1'b0;
      wrap_l  <= 1'b0;
      last_l  <= 1'b0;
      err_l   <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          2'd0:    base <= reg_wdata[AW-1:0];
          2'd1:    if (ml_ok) maxlen <= reg_wdata;
          2'd2:    {narrow, en} <= reg_wdata[1:0];
          default: if (ptr_ok) bdp <= reg_wdata[AW-1:0];
        endcase
      end
      unique case (st)
        S_IDLE: if (en) st <= S_HEAD;
        S_HEAD: begin
          if (!en) st <= S_IDLE;
          else if (bd_empty) begin
            wrap_l <= bd_rdata[30];
            st     <= S_ADDR;
          end
        end
        S_ADDR: begin
          buf_ptr <= bd_rdata[AW-1:0];
          cnt     <= maxlen;
          olen    <= maxlen;
          last_l  <= 1'b0;
          err_l   <= 1'b0;
          st      <= S_OPEN;
        end
        S_OPEN: begin
          if (in_valid) begin
            if (in_err) begin
              err_l <= 1'b1;
              st    <= S_CLOSE;
            end else begin
              buf_ptr <= buf_ptr + 1'b1;
              cnt     <= cnt - 16'd1;
              if (in_eof) begin
                last_l <= 1'b1;
                st     <= S_CLOSE;
              end else if (cnt == 16'd1) begin
                st <= S_CLOSE;
              end
            end
          end
        end
        S_CLOSE: begin
          bdp <= wrap_l ? base : bdp + BD_STEP;
          st  <= en ? S_HEAD : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_bd_walker_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          busy,
  input logic          mem_we,
  input logic          mem_wbyte,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [AW-1:0] cur_bd,
  input logic          buf_open,
  input logic [15:0]   cnt
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wbyte) |-> cnt != 16'd0);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we && mem_wbyte) && mem_we && mem_wbyte) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r5_wb_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_wbyte) |-> !mem_wdata[31]);

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_open && $past(buf_open)) |-> $stable(cur_bd));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !mem_we));
endmodule

bind rx_bd_walker rx_bd_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy),
  .mem_we(mem_we), .mem_wbyte(mem_wbyte), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .cur_bd(cur_bd), .buf_open(buf_open), .cnt(cnt)
);

// File: tb/rx_bd_walker_tb_top.sv
module rx_bd_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz with 1 ns units

  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        in_valid = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, mem_we, mem_wbyte, busy;
  logic [7:0]  bd_raddr, mem_addr, cur_bd;
  logic [31:0] bd_rdata, mem_wdata;
  logic [7:0]  mem [256];

  rx_bd_walker dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
    .in_ready(in_ready), .bd_raddr(bd_raddr), .bd_rdata(bd_rdata), .mem_we(mem_we),
    .mem_wbyte(mem_wbyte), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .cur_bd(cur_bd)
  );

  assign bd_rdata = {mem[bd_raddr + 8'd3], mem[bd_raddr + 8'd2],
                     mem[bd_raddr + 8'd1], mem[bd_raddr]};

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata[7:0];
      if (!mem_wbyte) begin
        mem[mem_addr + 8'd1] <= mem_wdata[15:8];
        mem[mem_addr + 8'd2] <= mem_wdata[23:16];
        mem[mem_addr + 8'd3] <= mem_wdata[31:24];
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  int exp_idx = 0, cur_cap = 4, ml = 4, pat_base = 0, sent = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'(pat_base + j * 7);
  endfunction

  function automatic int bufa(input int i);
    return 8'h40 + i * 32;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic beat(input logic [7:0] d, input bit eof, input bit err);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_eof = eof; in_err = err;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  task automatic send(input int n, input bit eof_last);
    for (int j = 0; j < n; j++) begin
      beat(pat(sent), eof_last && j == n - 1, 1'b0);
      sent++;
    end
  endtask

  task automatic rearm();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mem[i*8]   = 8'd0; mem[i*8+1] = 8'd0; mem[i*8+2] = 8'd0;
      mem[i*8+3] = {1'b1, i == 2, 6'd0};
      mem[i*8+4] = 8'(bufa(i)); mem[i*8+5] = 8'd0; mem[i*8+6] = 8'd0; mem[i*8+7] = 8'd0;
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic close_chk(input int len, input bit last, input bit err,
                           input int start, input string req);
    logic [31:0] w0, ew;
    bit ok;
    w0 = {mem[exp_idx*8+3], mem[exp_idx*8+2], mem[exp_idx*8+1], mem[exp_idx*8]};
    ew = {1'b0, exp_idx == 2, last, err, 12'd0, 16'(len)};
    chk(w0 == ew, req, "descriptor writeback (R5)", w0, ew);
    ok = 1'b1;
    for (int k = 0; k < len; k++)
      if (mem[bufa(exp_idx) + k] != pat(start + k)) ok = 1'b0;
    chk(ok, "R4", "buffer bytes match", exp_idx, len);
    exp_idx = (exp_idx + 1) % 3;
  endtask

  task automatic model(input int n, input int c0, input int c1, input bit err, input string req);
    int fill, cap, start;
    fill = 0; cap = c0; start = 0;
    for (int j = 0; j < n; j++) begin
      fill++;
      if (j == n - 1 && !err) close_chk(fill, 1'b1, 1'b0, start, req);
      else if (fill == cap) begin
        close_chk(fill, 1'b0, 1'b0, start, req);
        start = j + 1; fill = 0; cap = c1;
      end
    end
    if (err) close_chk(fill, 1'b0, 1'b1, start, req);
  endtask

  task automatic wrap_up(input int n, input bit err, input string req);
    settle();
    model(n, cur_cap, ml, err, req);
    chk(cur_bd == 8'(exp_idx * 8), "R6", "descriptor pointer after frame", cur_bd, exp_idx * 8);
    rearm();
    settle();
    cur_cap = ml;
  endtask

  task automatic frame(input int n, input bit err, input string req);
    pat_base += 37; sent = 0;
    send(n, !err);
    if (err) beat(8'hEE, 1'b0, 1'b1);
    wrap_up(n, err, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R11", "in_ready in reset", in_ready, 0);
    chk(busy == 1'b0, "R11", "busy in reset", busy, 0);
    chk(mem_we == 1'b0, "R11", "mem_we in reset", mem_we, 0);
    chk(cur_bd == 8'd0, "R11", "pointer in reset", cur_bd, 0);
    rst_n = 1'b1;
    rearm();
    wr_reg(2'd3, 16'd8);
    chk(cur_bd == 8'd8, "R9", "pointer write while idle", cur_bd, 8);
    wr_reg(2'd3, 16'd0);
    chk(cur_bd == 8'd0, "R9", "pointer write back to base", cur_bd, 0);
    wr_reg(2'd1, 16'd4);
    wr_reg(2'd2, 16'd1);
    settle();
    chk(in_ready == 1'b1, "R1", "buffer opened after enable", in_ready, 1);

    for (int n = 1; n <= 9; n++) frame(n, 1'b0, "R2");
    for (int n = 0; n <= 6; n++) frame(n, 1'b1, "R3");

    wr_reg(2'd3, 16'h10);
    chk(cur_bd == 8'(exp_idx * 8), "R9", "pointer write ignored while open", cur_bd, exp_idx * 8);

    wr_reg(2'd1, 16'd6);
    wr_reg(2'd1, 16'd0);
    frame(10, 1'b0, "R8");

    wr_reg(2'd2, 16'd3);
    wr_reg(2'd1, 16'd3);
    ml = 3;
    frame(7, 1'b0, "R7");
    for (int n = 1; n <= 7; n++) frame(n, 1'b0, "R1");

    pat_base += 37; sent = 0;
    send(2, 1'b0);
    wr_reg(2'd1, 16'd8);
    ml = 8;
    send(10, 1'b1);
    wrap_up(12, 1'b0, "R7");

    begin
      int nxt, wr;
      nxt = (exp_idx + 1) % 3;
      @(negedge clk);
      mem[nxt*8+3][7] = 1'b0;
      pat_base += 37; sent = 0;
      fork
        send(10, 1'b1);
      join_none
      repeat (20) @(negedge clk);
      #1;
      chk(busy == 1'b1, "R10", "busy on full descriptor", busy, 1);
      chk(in_ready == 1'b0, "R10", "in_ready held low", in_ready, 0);
      wr = 0;
      repeat (5) begin
        @(negedge clk); #1;
        if (mem_we) wr++;
      end
      chk(wr == 0, "R10", "writes while stalled", wr, 0);
      @(negedge clk);
      mem[nxt*8+3][7] = 1'b1;
      wait fork;
      wrap_up(10, 1'b0, "R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule